// File: doc/BRIEF.md
# Tri-Axis Sample Queue Controller

This block holds tri-axis sample records in a circular queue. Each record carries an x, a y and a z word. A producer offers a record with a one-cycle strobe. A consumer asks for records with a pop request, and each accepted pop copies the oldest record into an output holding register. A two-bit mode input chooses how the queue behaves.

- In pass-through mode the queue is bypassed and each sample goes straight to the holding register.
- In fill mode the queue stops taking samples once it is full.
- In stream mode the queue keeps the newest records and discards the oldest.
- In capture mode the queue streams until a trigger arrives. It then keeps only the newest records, up to a programmed level, and from then on fills like fill mode.

Two status flags are produced. The level flag holds while the queue is at or above a programmed level. The overrun flag reports lost or endangered data.

The level input does two jobs: it is the threshold for the level flag and the number of records kept when a trigger is taken. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset on the second rising clock edge after the reset input rises. All outputs are registered and change on the clock edge that samples the inputs.

Top module: `axq_ctrl`

## Requirements
- R1: After reset, `count_o` is 0, `wmark_o` and `ovr_o` are 0, and all three holding outputs are 0.
- R2: Mode codes are 0 for pass-through, 1 for fill, 2 for stream and 3 for capture. In the three queue modes, records leave the queue in the order they arrived. `count_o` gives the number of stored records after each clock edge.
- R3: While `mode_i` is 0, the queue stores nothing and `count_o` is 0 after every edge. Any records held when the mode changes to 0 are discarded. A strobed sample is written directly into the holding register.
- R4: In fill mode the queue stores records until it holds DEPTH of them. A sample that arrives while the queue is full, with no pop in the same cycle, is dropped. In that case the count and the stored contents are unchanged.
- R5: In stream mode, a sample that arrives while the queue is full and no pop is taken removes the oldest record and appends the new one. The queue then holds the newest DEPTH records.
- R6: `wmark_o` sets after an edge that leaves the count equal to the sampled `level_i`. It clears after an edge that leaves the count below the level. Otherwise it keeps its value.
- R7: In capture mode, the first trigger trims the queue to the newest `level_i` records. The trim applies to the count that results from that cycle's push and pop. Before the trigger the queue streams as in R5; after it, the queue fills as in R4.
- R8: Once a trigger has been taken, later triggers have no effect on the queue. The trigger is armed again only after the mode has been 0 for at least one edge and is then set back to 3.
- R9: In pass-through mode, `ovr_o` sets when a sample arrives while the holding register still has an unread sample. A pop marks the holding register as read and clears `ovr_o`.
- R10: In the three queue modes, `ovr_o` is 1 after an edge exactly when that edge leaves the queue full. Any pop that frees a slot therefore clears it.
- R11: A pop on an empty queue in a queue mode leaves the holding register and the count unchanged.
- R12: A push and a pop in the same cycle are both carried out, so the count is unchanged. This applies in fill mode too, where a full queue accepts the push because the pop frees a slot.
- R13: An accepted pop loads the oldest record into the holding outputs at the same edge that lowers the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| mode_i | input | 2 | Operating mode: 0 pass-through, 1 fill, 2 stream, 3 capture |
| level_i | input | $clog2(DEPTH) | Level-flag threshold and number of records kept on a trigger |
| smp_vld_i | input | 1 | New-sample strobe |
| smp_x_i | input | DW | Sample x word |
| smp_y_i | input | DW | Sample y word |
| smp_z_i | input | DW | Sample z word |
| trig_i | input | 1 | Trigger event, used in capture mode |
| pop_i | input | 1 | Request to move the oldest record into the holding register |
| hold_x_o | output | DW | Holding register, x word |
| hold_y_o | output | DW | Holding register, y word |
| hold_z_o | output | DW | Holding register, z word |
| count_o | output | $clog2(DEPTH+1) | Number of records stored |
| wmark_o | output | 1 | Level flag |
| ovr_o | output | 1 | Overrun flag |

## Verification
The bench builds the block with DEPTH 8 and DW 8. With that depth, a handful of strobes fills the queue, wraps the pointers and forces overwrite in stream mode. The three-bit level field can then reach every trim size, including trims that discard almost the whole queue. Short runs in every mode cover:
- full-queue drops and overwrites;
- trigger re-arming through pass-through mode;
- a level of zero;
- pops on an empty queue.

// File: rtl/axq_pkg.sv
package axq_pkg;

  typedef enum logic [1:0] {
    AXQ_PASS   = 2'd0,
    AXQ_FILL   = 2'd1,
    AXQ_STREAM = 2'd2,
    AXQ_CAPT   = 2'd3
  } axq_mode_e;

endpackage

// File: rtl/axq_store.sv
module axq_store #(
  parameter int DEPTH = 32,
  parameter int RW    = 48,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [RW-1:0] rd_data
);

  logic [RW-1:0] slots [DEPTH];

  // storage array: no reset, written only on an accepted push
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slots[wr_addr] <= wr_data;
    end
  end

  assign rd_data = slots[rd_addr];

endmodule

// File: rtl/axq_seq.sv
module axq_seq
  import axq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  axq_mode_e     mode,
  input  logic          smp_vld,
  input  logic          pop_req,
  input  logic          trig_req,
  input  logic [LW-1:0] level,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] wr_ptr,
  output logic          wr_en,
  output logic          pop_ok,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic          trig_fire
);

  logic [PW-1:0] rd_d, wr_d, rd_mid;
  logic [CW-1:0] cnt_mid, lvl_ext;
  logic          seen_q, seen_d;
  logic          pass, full, hold_full, drop_old;

  always_comb begin
    pass      = (mode == AXQ_PASS);
    full      = (cnt_q == CW'(DEPTH));
    // fill behaviour: fill mode, or capture mode once triggered
    hold_full = (mode == AXQ_FILL) || ((mode == AXQ_CAPT) && seen_q);
    pop_ok    = pop_req && !pass && (cnt_q != '0);
    wr_en     = smp_vld && !pass && (!full || pop_ok || !hold_full);
    drop_old  = smp_vld && !pass && full && !pop_ok && !hold_full;

    rd_mid    = rd_ptr + PW'(pop_ok | drop_old);
    cnt_mid   = cnt_q + CW'(wr_en) - CW'(pop_ok) - CW'(drop_old);
    lvl_ext   = CW'(level);
    trig_fire = trig_req && (mode == AXQ_CAPT) && !seen_q;

    rd_d  = rd_mid;
    cnt_d = cnt_mid;
    wr_d  = wr_ptr + PW'(wr_en);
    if (trig_fire && (cnt_mid > lvl_ext)) begin
      cnt_d = lvl_ext;
      rd_d  = rd_mid + PW'(cnt_mid - lvl_ext);
    end
    seen_d = !pass && (seen_q || trig_fire);
    if (pass) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      rd_ptr <= rd_d;
      wr_ptr <= wr_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

endmodule

// File: rtl/axq_flags.sv
module axq_flags #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pass,
  input  logic          smp_vld,
  input  logic          pop_req,
  input  logic [CW-1:0] cnt_d,
  input  logic [LW-1:0] level,
  output logic          wm_q,
  output logic          ovr_q
);

  logic          wm_d, ovr_d, fresh_q, fresh_d;
  logic [CW-1:0] lvl_ext;

  always_comb begin
    lvl_ext = CW'(level);
    wm_d    = wm_q;
    if (cnt_d == lvl_ext) begin
      wm_d = 1'b1;
    end else if (cnt_d < lvl_ext) begin
      wm_d = 1'b0;
    end
    if (pass) begin
      fresh_d = smp_vld | (fresh_q & ~pop_req);
      ovr_d   = !pop_req && fresh_q && (smp_vld || ovr_q);
    end else begin
      fresh_d = 1'b0;
      ovr_d   = (cnt_d == CW'(DEPTH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q    <= 1'b0;
      ovr_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      wm_q    <= wm_d;
      ovr_q   <= ovr_d;
      fresh_q <= fresh_d;
    end
  end

endmodule

// File: rtl/axq_ctrl.sv
module axq_ctrl
  import axq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(DEPTH),
  localparam int RW   = 3 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic [LW-1:0] level_i,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] smp_x_i,
  input  logic [DW-1:0] smp_y_i,
  input  logic [DW-1:0] smp_z_i,
  input  logic          trig_i,
  input  logic          pop_i,
  output logic [DW-1:0] hold_x_o,
  output logic [DW-1:0] hold_y_o,
  output logic [DW-1:0] hold_z_o,
  output logic [CW-1:0] count_o,
  output logic          wmark_o,
  output logic          ovr_o
);

  logic          rst_meta, rst_sync;
  axq_mode_e     mode;
  logic          pass;
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          wr_en, pop_ok, trig_fire;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] smp_rec, old_rec, hold_q, hold_d;
  logic          hold_en;

  // reset: asserts at once, leaves on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign mode    = axq_mode_e'(mode_i);
  assign pass    = (mode == AXQ_PASS);
  assign smp_rec = {smp_x_i, smp_y_i, smp_z_i};

  axq_seq #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync),
    .mode     (mode),
    .smp_vld  (smp_vld_i),
    .pop_req  (pop_i),
    .trig_req (trig_i),
    .level    (level_i),
    .rd_ptr   (rd_ptr),
    .wr_ptr   (wr_ptr),
    .wr_en    (wr_en),
    .pop_ok   (pop_ok),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .trig_fire(trig_fire)
  );

  axq_store #(.DEPTH(DEPTH), .RW(RW)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_ptr),
    .wr_data(smp_rec),
    .rd_addr(rd_ptr),
    .rd_data(old_rec)
  );

  axq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync),
    .pass   (pass),
    .smp_vld(smp_vld_i),
    .pop_req(pop_i),
    .cnt_d  (cnt_d),
    .level  (level_i),
    .wm_q   (wmark_o),
    .ovr_q  (ovr_o)
  );

  // holding register: direct sample in pass-through, oldest record on pop
  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_q;
    if (pass && smp_vld_i) begin
      hold_en = 1'b1;
      hold_d  = smp_rec;
    end else if (pop_ok) begin
      hold_en = 1'b1;
      hold_d  = old_rec;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign {hold_x_o, hold_y_o, hold_z_o} = hold_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/axq_ctrl_chk.sv
module axq_ctrl_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int CW    = 6,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic [LW-1:0] level_i,
  input logic          smp_vld_i,
  input logic          trig_i,
  input logic          pop_i,
  input logic [3*DW-1:0] hold,
  input logic [CW-1:0] count_o,
  input logic          wmark_o,
  input logic          ovr_o,
  input logic          trig_fire
);

  // R2: the count never exceeds the queue depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  a_r3_pass_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |=> (count_o == '0));

  a_r4_fill_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && count_o == CW'(DEPTH) && !pop_i)
      |=> (count_o == CW'(DEPTH) && $stable(hold)));

  a_r5_stream_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && smp_vld_i && count_o == CW'(DEPTH))
      |=> (count_o == CW'(DEPTH)));

  a_r6_level_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((count_o != CW'($past(level_i)) || wmark_o) &&
              (count_o >= CW'($past(level_i)) || !wmark_o)));

  a_r7_trig_trim: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> (count_o <= CW'($past(level_i))));

  a_r9_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && pop_i) |=> !ovr_o);

  a_r10_full_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd0) |=> (ovr_o == (count_o == CW'(DEPTH))));

  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd0 && count_o == '0 && pop_i && !smp_vld_i)
      |=> ($stable(hold) && count_o == '0));

  a_r12_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd0 && smp_vld_i && pop_i && !trig_i && count_o != '0)
      |=> $stable(count_o));

endmodule

bind axq_ctrl axq_ctrl_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync),
  .mode_i   (mode_i),
  .level_i  (level_i),
  .smp_vld_i(smp_vld_i),
  .trig_i   (trig_i),
  .pop_i    (pop_i),
  .hold     ({hold_x_o, hold_y_o, hold_z_o}),
  .count_o  (count_o),
  .wmark_o  (wmark_o),
  .ovr_o    (ovr_o),
  .trig_fire(trig_fire)
);

// File: tb/axq_ctrl_bench.sv
module axq_ctrl_bench;

  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int LW    = $clog2(DEPTH);
  typedef logic [3*DW-1:0] rec_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic [LW-1:0] level;
  logic          smp_vld, trig, pop;
  logic [DW-1:0] sx, sy, sz, hx, hy, hz;
  logic [CW-1:0] count;
  logic          wmark, ovr;

  int n_chk = 0;
  int n_err = 0;
  int cyc_n = 0;
  int next_id = 1;

  rec_t mq[$];
  rec_t sb[$];
  rec_t m_hold = '0;
  rec_t mon_exp;
  bit   m_fresh = 0, m_ovr = 0, m_wm = 0, m_trig = 0;

  always #4 clk = ~clk;

  axq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_axq_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .level_i(level),
    .smp_vld_i(smp_vld), .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz),
    .trig_i(trig), .pop_i(pop),
    .hold_x_o(hx), .hold_y_o(hy), .hold_z_o(hz),
    .count_o(count), .wmark_o(wmark), .ovr_o(ovr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic rec_t mk(input int id);
    logic [DW-1:0] b = DW'(id);
    return {b, b ^ DW'(8'h55), ~b};
  endfunction

  // reference model of the requirements
  function automatic void model(input bit vld, input rec_t d, input bit pp, input bit tg);
    int  lvl = int'(level);
    bit  fill_like, full, popped;
    if (mode == 2'd0) begin
      mq.delete();
      m_trig = 0;
      if (pp) m_ovr = 0;
      else    m_ovr = m_fresh && (vld || m_ovr);
      if (vld) begin m_hold = d; m_fresh = 1; end
      else if (pp) m_fresh = 0;
    end else begin
      m_fresh   = 0;
      fill_like = (mode == 2'd1) || (mode == 2'd3 && m_trig);
      full      = (mq.size() == DEPTH);
      popped    = pp && (mq.size() > 0);
      if (popped) begin
        m_hold = mq.pop_front();
        sb.push_back(m_hold);
      end
      if (vld) begin
        if (!full || popped) mq.push_back(d);
        else if (!fill_like) begin
          void'(mq.pop_front());
          mq.push_back(d);
        end
      end
      if (mode == 2'd3 && !m_trig && tg) begin
        m_trig = 1;
        while (mq.size() > lvl) void'(mq.pop_front());
      end
      m_ovr = (mq.size() == DEPTH);
    end
    if (mq.size() == lvl) m_wm = 1;
    else if (mq.size() < lvl) m_wm = 0;
  endfunction

  // driver: one clock cycle of stimulus, model update, output checks
  task automatic cyc(input bit vld, input bit pp, input bit tg, input string tag);
    rec_t d = mk(next_id);
    if (vld) next_id++;
    smp_vld = vld; {sx, sy, sz} = d; pop = pp; trig = tg;
    @(posedge clk);
    model(vld, d, pp, tg);
    @(negedge clk);
    smp_vld = 0; pop = 0; trig = 0;
    chk(tag, "count", int'(count), mq.size());
    chk(tag, "wmark", int'(wmark), int'(m_wm));
    chk(tag, "ovr", int'(ovr), int'(m_ovr));
    chk(tag, "hold", int'({hx, hy, hz}), int'(m_hold));
  endtask

  // monitor: every popped record must appear at the holding outputs (R13)
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      mon_exp = sb.pop_front();
      chk("R13", "popped record", int'({hx, hy, hz}), int'(mon_exp));
    end
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n == 20000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode = 2'd0; level = 3'd1;
    smp_vld = 0; trig = 0; pop = 0; sx = '0; sy = '0; sz = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "wmark", int'(wmark), 0);
    chk("R1", "ovr", int'(ovr), 0);
    chk("R1", "hold", int'({hx, hy, hz}), 0);

    // R4 fill mode with R6 level flag and R10 overrun when full
    mode = 2'd1; level = 3'd4;
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, "R4");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R2");
    for (int i = 0; i < 2; i++) cyc(0, 1, 0, "R6");
    for (int i = 0; i < 2; i++) cyc(1, 1, 0, "R12");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R13");
    for (int i = 0; i < 2; i++) cyc(0, 1, 0, "R11");
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, "R10");
    cyc(1, 1, 0, "R12");
    cyc(0, 1, 0, "R10");

    // R5 stream mode overwrites the oldest
    mode = 2'd2; level = 3'd6;
    for (int i = 0; i < 11; i++) cyc(1, 0, 0, "R5");
    cyc(1, 1, 0, "R12");
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, "R5");

    // R3 entering pass-through empties the queue
    mode = 2'd0;
    cyc(0, 0, 0, "R3");
    // R7 capture: stream, trim on trigger, then fill
    mode = 2'd3; level = 3'd3;
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, "R7");
    cyc(0, 0, 1, "R7");
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, "R7");
    for (int i = 0; i < 2; i++) cyc(0, 1, 0, "R7");
    // R8 a second trigger is ignored
    cyc(0, 0, 1, "R8");
    cyc(1, 0, 1, "R8");
    // R8 re-arm through pass-through
    mode = 2'd0;
    cyc(0, 0, 0, "R3");
    mode = 2'd3;
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R8");
    cyc(1, 1, 1, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R8");

    // R3 queued stream data dropped on entering pass-through
    mode = 2'd2;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R3");
    mode = 2'd0;
    cyc(0, 0, 0, "R3");
    // R9 pass-through overrun
    cyc(1, 0, 0, "R3");
    cyc(1, 0, 0, "R9");
    cyc(0, 0, 0, "R9");
    cyc(0, 1, 0, "R9");
    cyc(1, 1, 0, "R9");
    cyc(1, 0, 0, "R9");
    cyc(0, 1, 0, "R9");

    // R6 level zero holds the flag on an empty queue
    mode = 2'd1; level = 3'd0;
    cyc(0, 0, 0, "R6");
    cyc(1, 0, 0, "R6");
    cyc(0, 1, 0, "R6");

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule